// File: doc/BRIEF.md
# Free-Running Cycle Counter with Torn-Read Detection

This block keeps a wide cycle counter that advances by one on every clock while counting is switched on. Software on a 32-bit register port cannot fetch the whole count in one access, so it reads the lower half and the upper half separately. Between those two reads the lower half may carry into the upper half. The two halves then come from different counter values, and the combined result is wrong.

The block does not keep a frozen copy of the full count. It watches the read sequence instead. A read of the lower half records the upper half and raises a consistency flag. A later read of the upper half drops the flag if the upper half has moved since then. Software reads the lower half, then the upper half, then the control word. It repeats the three reads until the flag in the top bit of the control word is 1. The only other control bit is the count enable in bit 0.

Top module: `cyc_ctr_top`

## Requirements
- R1: A synchronous reset clears the count, the enable and the consistency flag, and drives the read data to 0.
- R2: A write to the control address (0x103) with bit 0 set enables counting. From the second clock edge after the write, the count grows by exactly one per edge.
- R3: A write to the control address with bit 0 clear stops the count, and the count keeps its value.
- R4: A read of 0x104 returns the lower half of the count as it stood at the read edge. A read of 0x105 returns the upper half. Data appears the cycle after the read strobe, zero-extended to the port width, and holds until the next read.
- R5: A read of 0x103 returns the flag in bit 31, the enable in bit 0 and 0 in every other bit.
- R6: A read of the lower half sets the flag to 1.
- R7: A read of the upper half clears the flag when the upper half differs from its value at the last lower-half read. Once clear, the flag stays 0 until the next lower-half read.
- R8: Writes to the counter-half addresses do not change the count. Write data bits other than bit 0 have no effect, so bit 31 cannot be set by software.
- R9: A read of any address other than the three above returns 0.
- R10: The count wraps from all ones to zero. A carry out of the lower half moves into the upper half on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_rd | input | 1 | Read strobe, one cycle per access |
| aux_wr | input | 1 | Write strobe, one cycle per access |
| aux_addr | input | AUX_AW (12) | Register address |
| aux_wdata | input | DATA_W (32) | Write data |
| aux_rdata | output | DATA_W (32) | Registered read data |

## Verification
Read data is registered. It reflects the counter and flag as they stood at the strobe's edge, and the bench samples it one time unit after that edge. An enable write lands in its register at the write edge, so the count first moves at the following edge. A flag change made by a half read becomes visible only through a control read issued in a later cycle. The bench keeps a model of the count that it updates at the same edges, in the order described here. A second instance with a 16-bit count makes the carry between halves, the torn read and the wrap reachable within the cycle budget.

// File: rtl/cyc_ctr_pkg.sv
package cyc_ctr_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } cc_sel_e;

  localparam int unsigned EN_POS      = 0;
  localparam int unsigned AW_DEF      = 12;
  localparam logic [11:0] A_CTRL_DEF  = 12'h103;
  localparam logic [11:0] A_LO_DEF    = 12'h104;
  localparam logic [11:0] A_HI_DEF    = 12'h105;

endpackage

// File: rtl/cyc_ctr_decode.sv
module cyc_ctr_decode
  import cyc_ctr_pkg::*;
#(
  parameter int unsigned    AW     = AW_DEF,
  parameter logic [AW-1:0]  A_CTRL = A_CTRL_DEF,
  parameter logic [AW-1:0]  A_LO   = A_LO_DEF,
  parameter logic [AW-1:0]  A_HI   = A_HI_DEF
) (
  input  logic [AW-1:0] addr,
  output cc_sel_e       sel
);

  // Address to target; unmapped addresses fall to SEL_NONE (R9)
  always_comb begin
    if (addr == A_CTRL)      sel = SEL_CTRL;
    else if (addr == A_LO)   sel = SEL_LO;
    else if (addr == A_HI)   sel = SEL_HI;
    else                     sel = SEL_NONE;
  end

endmodule

// File: rtl/cyc_ctr_count.sv
module cyc_ctr_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en_bit,
  output logic             en,
  output logic [CNT_W-1:0] cnt
);

  // Enable bit: loaded by a control write (R2, R3)
  always_ff @(posedge clk) begin
    if (rst)         en <= 1'b0;
    else if (ctl_wr) en <= ctl_en_bit;
  end

  // One full-width incrementer; carry between halves is same-edge (R10)
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + CNT_W'(1);
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !en);                                  // R1
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (en == $past(ctl_en_bit)));                        // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> (cnt == $past(cnt) + CNT_W'(1)));                      // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));                                        // R3

endmodule

// File: rtl/cyc_ctr_tear.sv
module cyc_ctr_tear #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_rd,
  input  logic              hi_rd,
  input  logic [HALF_W-1:0] hi_now,
  output logic              ok
);

  logic [HALF_W-1:0] hi_snap;

  // Lower-half read snapshots the upper half and arms the flag (R6);
  // an upper-half read that sees a different upper half clears it (R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_snap <= '0;
      ok      <= 1'b0;
    end else if (lo_rd) begin
      hi_snap <= hi_now;
      ok      <= 1'b1;
    end else if (hi_rd && (hi_now != hi_snap)) begin
      ok      <= 1'b0;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> ok);                                                // R6
  AST_FLAG_TEAR: assert property (@(posedge clk) disable iff (rst)
    (hi_rd && !lo_rd && (hi_now != hi_snap)) |=> !ok);            // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!lo_rd && !ok) |=> !ok);                                     // R7

endmodule

// File: rtl/cyc_ctr_rdport.sv
module cyc_ctr_rdport
  import cyc_ctr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  cc_sel_e           sel,
  input  logic [HALF_W-1:0] lo,
  input  logic [HALF_W-1:0] hi,
  input  logic              ok,
  input  logic              en,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] lo_x;
  logic [DATA_W-1:0] hi_x;
  logic [DATA_W-1:0] ctrl_w;

  // Width adaptation of the counter halves to the port (R4)
  generate
    if (HALF_W == DATA_W) begin : g_full
      assign lo_x = lo;
      assign hi_x = hi;
    end else begin : g_pad
      assign lo_x = {{(DATA_W-HALF_W){1'b0}}, lo};
      assign hi_x = {{(DATA_W-HALF_W){1'b0}}, hi};
    end
  endgenerate

  // Control word: flag on top, enable at EN_POS, rest zero (R5)
  always_comb begin
    ctrl_w             = '0;
    ctrl_w[DATA_W-1]   = ok;
    ctrl_w[EN_POS]     = en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (sel)
        SEL_CTRL: rdata <= ctrl_w;
        SEL_LO:   rdata <= lo_x;
        SEL_HI:   rdata <= hi_x;
        default:  rdata <= '0;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));                                      // R4
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_CTRL) |=> (rdata[DATA_W-2:1] == '0));       // R5
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_NONE) |=> (rdata == '0));                   // R9

endmodule

// File: rtl/cyc_ctr_top.sv
module cyc_ctr_top
  import cyc_ctr_pkg::*;
#(
  parameter int unsigned       CNT_W  = 64,
  parameter int unsigned       DATA_W = 32,
  parameter int unsigned       AUX_AW = AW_DEF,
  parameter logic [AUX_AW-1:0] A_CTRL = A_CTRL_DEF,
  parameter logic [AUX_AW-1:0] A_LO   = A_LO_DEF,
  parameter logic [AUX_AW-1:0] A_HI   = A_HI_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aux_rd,
  input  logic              aux_wr,
  input  logic [AUX_AW-1:0] aux_addr,
  input  logic [DATA_W-1:0] aux_wdata,
  output logic [DATA_W-1:0] aux_rdata
);

  localparam int unsigned HALF_W = CNT_W / 2;

  cc_sel_e           sel;
  logic              ctl_wr;
  logic              lo_rd;
  logic              hi_rd;
  logic              en;
  logic              ok;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wdata_unused;

  // Only the enable bit of write data matters (R8)
  assign wdata_unused = aux_wdata;

  cyc_ctr_decode #(
    .AW     (AUX_AW),
    .A_CTRL (A_CTRL),
    .A_LO   (A_LO),
    .A_HI   (A_HI)
  ) u_dec (
    .addr (aux_addr),
    .sel  (sel)
  );

  assign ctl_wr = aux_wr && (sel == SEL_CTRL);
  assign lo_rd  = aux_rd && (sel == SEL_LO);
  assign hi_rd  = aux_rd && (sel == SEL_HI);

  cyc_ctr_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr     (ctl_wr),
    .ctl_en_bit (aux_wdata[EN_POS]),
    .en         (en),
    .cnt        (cnt)
  );

  cyc_ctr_tear #(
    .HALF_W (HALF_W)
  ) u_tear (
    .clk    (clk),
    .rst    (rst),
    .lo_rd  (lo_rd),
    .hi_rd  (hi_rd),
    .hi_now (cnt[CNT_W-1:HALF_W]),
    .ok     (ok)
  );

  cyc_ctr_rdport #(
    .DATA_W (DATA_W),
    .HALF_W (HALF_W)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (aux_rd),
    .sel   (sel),
    .lo    (cnt[HALF_W-1:0]),
    .hi    (cnt[CNT_W-1:HALF_W]),
    .ok    (ok),
    .en    (en),
    .rdata (aux_rdata)
  );

  // Half writes leave the count alone (R8)
  AST_HALF_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (aux_wr && !en && (sel == SEL_LO || sel == SEL_HI)) |=> $stable(cnt)); // R8

endmodule

// File: tb/tb_cyc_ctr_top.sv
module tb_cyc_ctr_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [11:0] AC = 12'h103;
  localparam logic [11:0] AL = 12'h104;
  localparam logic [11:0] AH = 12'h105;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;
  localparam int NV = 16;

  // {op, tag, addr, data}
  localparam logic [49:0] VEC [NV] = '{
    {OP_RD,   4'd1, AC, 32'h0},          // R1 control after reset
    {OP_WR,   4'd8, AC, 32'h8000_0000},  // R8 try to set flag
    {OP_RD,   4'd8, AC, 32'h0},          // R8 flag still 0
    {OP_WR,   4'd2, AC, 32'h1},          // R2 enable
    {OP_RD,   4'd2, AL, 32'h0},          // R2 not yet moved
    {OP_RD,   4'd2, AL, 32'h0},          // R2 moved by one
    {OP_IDLE, 4'd2, AC, 32'd5},
    {OP_RD,   4'd4, AL, 32'h0},          // R4 lower half
    {OP_RD,   4'd4, AH, 32'h0},          // R4 upper half
    {OP_RD,   4'd5, AC, 32'h0},          // R5 R6 flag and enable
    {OP_WR,   4'd3, AC, 32'hFFFF_FFFE},  // R3 stop, R8 other bits
    {OP_RD,   4'd3, AL, 32'h0},          // R3
    {OP_IDLE, 4'd3, AC, 32'd4},
    {OP_WR,   4'd8, AL, 32'h0000_1234},  // R8 write to half
    {OP_RD,   4'd3, AL, 32'h0},          // R3 R8 value kept
    {OP_RD,   4'd9, 12'h200, 32'h0}      // R9 unmapped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aux_rd = 1'b0;
  logic        aux_wr = 1'b0;
  logic [11:0] aux_addr = '0;
  logic [31:0] aux_wdata = '0;
  logic [31:0] rdata_w;
  logic [31:0] rdata_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [63:0] m = '0;
  logic        men = 1'b0;
  logic        fw = 1'b0, fn = 1'b0;
  logic [31:0] sw = '0;
  logic [7:0]  sn = '0;
  logic [31:0] ew = '0, exn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_ctr_top dut (
    .clk(clk), .rst(rst), .aux_rd(aux_rd), .aux_wr(aux_wr),
    .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_rdata(rdata_w)
  );

  cyc_ctr_top #(.CNT_W(16)) dut_n (
    .clk(clk), .rst(rst), .aux_rd(aux_rd), .aux_wr(aux_wr),
    .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_rdata(rdata_n)
  );

  // Narrow instance count equals m[15:0]; its halves are bytes
  always @(posedge clk) begin
    if (rst) begin
      m = '0; men = 1'b0; fw = 1'b0; fn = 1'b0; sw = '0; sn = '0;
      ew = '0; exn = '0;
    end else begin
      if (aux_rd) begin
        case (aux_addr)
          AC: begin ew = {fw, 30'b0, men}; exn = {fn, 30'b0, men}; end
          AL: begin
            ew = m[31:0]; exn = {24'b0, m[7:0]};
            sw = m[63:32]; fw = 1'b1; sn = m[15:8]; fn = 1'b1;
          end
          AH: begin
            ew = m[63:32]; exn = {24'b0, m[15:8]};
            if (m[63:32] != sw) fw = 1'b0;
            if (m[15:8] != sn) fn = 1'b0;
          end
          default: begin ew = '0; exn = '0; end
        endcase
      end
      m = m + {63'b0, men};
      if (aux_wr && aux_addr == AC) men = aux_wdata[0];
    end
  end

  task automatic chk(input int tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive one access, check both ports after the edge
  task automatic op_now(input logic [1:0] op, input logic [11:0] a,
                        input logic [31:0] d, input int tag);
    aux_rd = (op == OP_RD); aux_wr = (op == OP_WR);
    aux_addr = a; aux_wdata = d;
    @(posedge clk); #1;
    aux_rd = 1'b0; aux_wr = 1'b0;
    chk(tag, rdata_w, ew);
    chk(tag, rdata_n, exn);
  endtask

  task automatic op(input logic [1:0] o, input logic [11:0] a,
                    input logic [31:0] d, input int tag);
    @(negedge clk);
    op_now(o, a, d, tag);
  endtask

  task automatic wait_n(input logic [15:0] v, input logic [15:0] mask);
    @(negedge clk);
    while ((m[15:0] & mask) != v) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(1, rdata_w, 32'h0);                                   // R1
    chk(1, rdata_n, 32'h0);                                   // R1
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][49:48] == OP_IDLE)
        repeat (VEC[i][31:0]) @(negedge clk);
      else
        op(VEC[i][49:48], VEC[i][43:32], VEC[i][31:0], int'(VEC[i][47:44]));
    end

    // R2 explicit step of one per edge
    op(OP_WR, AC, 32'h1, 2);
    op(OP_RD, AL, 32'h0, 2);
    begin
      logic [31:0] first;
      first = rdata_w;
      op(OP_RD, AL, 32'h0, 2);
      chk(2, rdata_w, first + 32'd1);                         // R2
    end

    // R7 torn read on narrow: lower byte 0xFF at the lower read
    wait_n(16'h00FF, 16'h00FF);
    op_now(OP_RD, AL, 32'h0, 7);
    op(OP_RD, AH, 32'h0, 7);
    op(OP_RD, AC, 32'h0, 7);
    chk(7, {31'b0, rdata_n[31]}, 32'h0);                      // R7 narrow torn
    chk(6, {31'b0, rdata_w[31]}, 32'h1);                      // R6 wide intact
    op(OP_RD, AH, 32'h0, 7);
    op(OP_RD, AC, 32'h0, 7);
    chk(7, {31'b0, rdata_n[31]}, 32'h0);                      // R7 sticky
    op(OP_RD, AL, 32'h0, 6);
    op(OP_RD, AH, 32'h0, 6);
    op(OP_RD, AC, 32'h0, 6);
    chk(6, {31'b0, rdata_n[31]}, 32'h1);                      // R6 retry ok

    // R10 wrap of the narrow counter
    wait_n(16'hFFFF, 16'hFFFF);
    op_now(OP_RD, AH, 32'h0, 10);
    chk(10, rdata_n, 32'h0000_00FF);                          // R10
    op(OP_RD, AL, 32'h0, 10);
    chk(10, rdata_n, 32'h0);                                  // R10 wrapped
    op(OP_RD, AH, 32'h0, 10);
    chk(10, rdata_n, 32'h0);                                  // R10 carry

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(posedge clk); #1;
    chk(1, rdata_w, 32'h0);                                   // R1
    @(negedge clk); rst = 1'b0;
    op(OP_RD, AC, 32'h0, 1);
    chk(1, rdata_w, 32'h0);                                   // R1
    op(OP_RD, AL, 32'h0, 1);
    chk(1, rdata_w, 32'h0);                                   // R1

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule